// File: doc/BRIEF.md
# Teletext Request and Insertion Window Controller

This controller times teletext insertion on each video line, measured from the horizontal sync leading edge. It sends a one-clock request strobe to an external serial bit source for every bit it needs. It samples each returned bit after a delay that software programs, and it queues the samples in a small buffer. A fixed-length insertion window then opens at a fixed offset after the sync edge, and the buffered bits come out one per bit period on a gated output with a valid flag.

The bit pacing comes from a 24-bit phase accumulator that runs at the 27 MHz pixel clock. The increment is the bit rate divided by 27 MHz, scaled to 2^24. The standard sets the increment, the bit count and the window offset. The timebase supplies a line-start pulse, a field-start pulse, the line number and the field parity. Only lines inside the programmed range for the current field take part. The enable and the standard are sampled once per field.

Top module: `ttx_window_ctrl`

## Requirements
- R1: Synchronous reset drives `ttx_req`, `ins_valid` and `ins_bit` low and clears the latched enable, so no line is served until a new `field_start` arrives with `ttx_en` high.
- R2: Request pulses are one clock wide. Call the line position the number of clock edges since the edge that sampled `hsync_lead`. The first request is high at a position from `req_start`+2 to `req_start`+6. Consecutive requests are floor(2^24/INC) or floor(2^24/INC)+1 clocks apart. INC is 4310812 for `ttx_std`=0 (625-line) and 3558758 for `ttx_std`=1 (world 525-line) or 2 (NABTS).
- R3: A served line carries exactly 360 (code 0), 296 (code 1) or 288 (code 2) request pulses.
- R4: If a request is high after edge r, `ttx_bit_in` is sampled at edge r+`data_delay` (`data_delay` from 1 to 32). Sampled bits are inserted in the same order as the requests.
- R5: On a served line, `ins_valid` rises at position 275 for code 0 and at position 284 for codes 1 and 2.
- R6: `ins_valid` stays high for ceil(N*2^24/INC) clocks, where N is the bit count from R3. At position W+k (W from R5) `ins_bit` carries captured bit number floor(k*INC/2^24). `ins_bit` changes only at bit boundaries.
- R7: `ttx_en` is sampled only on a `field_start` cycle. If it was 0 there, that field has no requests and no window. A change to `ttx_en` later in the field has no effect.
- R8: An odd field (`field_odd`=1) serves lines `odd_first`..`odd_last`, and an even field serves lines `even_first`..`even_last`, both bounds inclusive. `line_num` and `field_odd` are taken on the `hsync_lead` cycle. Other lines produce no requests and no window.
- R9: `ttx_std` is sampled only on a `field_start` cycle. A change later in the field does not alter the bit count, the rate or the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_lead | input | 1 | One-clock pulse at the sync leading edge (line start) |
| field_start | input | 1 | One-clock pulse at field start; samples enable and standard |
| field_odd | input | 1 | 1 = odd field, taken at line start |
| line_num | input | 10 | Current line number, taken at line start |
| ttx_en | input | 1 | Teletext enable |
| ttx_std | input | 2 | 0 = 625-line, 1 = world 525-line, 2 = NABTS |
| odd_first | input | 10 | First served line of odd fields |
| odd_last | input | 10 | Last served line of odd fields |
| even_first | input | 10 | First served line of even fields |
| even_last | input | 10 | Last served line of even fields |
| req_start | input | 11 | Line position at which request pacing starts |
| data_delay | input | 6 | Clocks from a request to bit sampling, 1..32 |
| ttx_bit_in | input | 1 | Serial bit from the external source |
| ttx_req | output | 1 | Request strobe, one pulse per wanted bit |
| ins_bit | output | 1 | Gated teletext bit for insertion |
| ins_valid | output | 1 | High during the insertion window |

## Verification
Requests keep arriving after the window opens, so the capture of a requested bit into the buffer and the removal of a bit for insertion fall in the same clock again and again. The window cannot be served without this. The bench sets the request start 35 clocks before the window and uses delays of 1, 10 and 20 clocks, so the buffer runs both near-empty and several entries deep during the overlap. For each line it judges the result by comparing every inserted bit, position by position, against the pattern it fed to the requests in order. One lost, doubled or reordered bit in a simultaneous write and read shows up as a mismatch.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
  localparam int ACC_W = 24;

  typedef enum logic [1:0] {
    STD_625   = 2'd0,
    STD_W525  = 2'd1,
    STD_NABTS = 2'd2
  } ttx_std_e;

  function automatic logic [ACC_W-1:0] std_inc(ttx_std_e s);
    return (s == STD_625) ? 24'd4310812 : 24'd3558758;
  endfunction

  function automatic int std_bits(ttx_std_e s);
    case (s)
      STD_625:  return 360;
      STD_W525: return 296;
      default:  return 288;
    endcase
  endfunction

  function automatic int std_ofs(ttx_std_e s);
    return (s == STD_625) ? 275 : 284;
  endfunction
endpackage

// File: rtl/ttx_line_sel.sv
module ttx_line_sel
  import ttx_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync_lead,
  input  logic              field_start,
  input  logic              field_odd,
  input  logic [LINE_W-1:0] line_num,
  input  logic              ttx_en,
  input  logic [1:0]        ttx_std,
  input  logic [LINE_W-1:0] odd_first,
  input  logic [LINE_W-1:0] odd_last,
  input  logic [LINE_W-1:0] even_first,
  input  logic [LINE_W-1:0] even_last,
  output logic              line_ok,
  output ttx_std_e          std_q
);
  logic en_q;
  logic in_odd, in_even;

  assign in_odd  = (line_num >= odd_first)  && (line_num <= odd_last);
  assign in_even = (line_num >= even_first) && (line_num <= even_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      std_q   <= STD_625;
      line_ok <= 1'b0;
    end else begin
      if (field_start) begin
        en_q  <= ttx_en;
        std_q <= ttx_std_e'(ttx_std);
      end
      if (hsync_lead)
        line_ok <= en_q && (field_odd ? in_odd : in_even);
    end
  end
endmodule

// File: rtl/ttx_rate_gen.sv
module ttx_rate_gen #(
  parameter int ACC_W = 24,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             start,
  input  logic [ACC_W-1:0] inc,
  input  logic [CNT_W-1:0] limit,
  output logic             step,
  output logic             last,
  output logic             busy
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;
  logic [CNT_W-1:0] cnt;

  assign sum  = {1'b0, acc} + {1'b0, inc};
  assign step = busy && sum[ACC_W];
  assign last = step && (CNT_W'(cnt + 1'b1) == limit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy <= 1'b0;
      acc  <= '0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      acc  <= '0;
      cnt  <= '0;
    end else if (busy) begin
      acc <= sum[ACC_W-1:0];
      if (step) cnt <= cnt + 1'b1;
      if (last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/ttx_bit_fifo.sv
module ttx_bit_fifo #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic push,
  input  logic din,
  input  logic pop,
  output logic dout
);
  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    wptr, rptr;
  logic [AW:0]      fill;
  logic             wr_en, rd_en;

  assign rd_en = pop && (fill != '0);
  assign wr_en = push && ((fill != (AW+1)'(DEPTH)) || rd_en);
  assign dout  = (fill != '0) ? mem[rptr] : 1'b0;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      if (rd_en) rptr <= rptr + 1'b1;
      fill <= fill + {{AW{1'b0}}, wr_en} - {{AW{1'b0}}, rd_en};
    end
  end
endmodule

// File: rtl/ttx_window_ctrl.sv
module ttx_window_ctrl
  import ttx_pkg::*;
#(
  parameter int LINE_W  = 10,
  parameter int POS_W   = 11,
  parameter int DLY_MAX = 32,
  parameter int FIFO_D  = 32,
  parameter int CNT_W   = 9,
  localparam int DLY_W  = $clog2(DLY_MAX) + 1,
  localparam int DLY_IW = $clog2(DLY_MAX)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync_lead,
  input  logic              field_start,
  input  logic              field_odd,
  input  logic [LINE_W-1:0] line_num,
  input  logic              ttx_en,
  input  logic [1:0]        ttx_std,
  input  logic [LINE_W-1:0] odd_first,
  input  logic [LINE_W-1:0] odd_last,
  input  logic [LINE_W-1:0] even_first,
  input  logic [LINE_W-1:0] even_last,
  input  logic [POS_W-1:0]  req_start,
  input  logic [DLY_W-1:0]  data_delay,
  input  logic              ttx_bit_in,
  output logic              ttx_req,
  output logic              ins_bit,
  output logic              ins_valid
);
  logic             line_ok;
  ttx_std_e         std_q;
  logic [POS_W-1:0] pos;
  logic [ACC_W-1:0] inc;
  logic [CNT_W-1:0] nbits;
  logic [POS_W-1:0] win_pre;
  logic             req_go, ins_go;
  logic             req_step, req_last, req_busy;
  logic             ins_step, ins_last, ins_busy;
  logic             ins_pop, cap, fifo_out;
  logic [DLY_MAX-1:0] taps;
  logic [DLY_IW-1:0]  dsel;

  ttx_line_sel #(.LINE_W(LINE_W)) u_sel (
    .clk(clk), .rst(rst), .hsync_lead(hsync_lead), .field_start(field_start),
    .field_odd(field_odd), .line_num(line_num), .ttx_en(ttx_en), .ttx_std(ttx_std),
    .odd_first(odd_first), .odd_last(odd_last), .even_first(even_first),
    .even_last(even_last), .line_ok(line_ok), .std_q(std_q)
  );

  assign inc     = std_inc(std_q);
  assign nbits   = CNT_W'(std_bits(std_q));
  assign win_pre = POS_W'(std_ofs(std_q) - 1);

  // Line position: edges since the line-start edge, saturating.
  always_ff @(posedge clk) begin
    if (rst || hsync_lead)  pos <= '0;
    else if (pos != '1)     pos <= pos + 1'b1;
  end

  assign req_go = line_ok && !hsync_lead && (pos == req_start);
  assign ins_go = line_ok && !hsync_lead && (pos == win_pre);

  ttx_rate_gen #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_req_rate (
    .clk(clk), .rst(rst), .clr(hsync_lead), .start(req_go), .inc(inc),
    .limit(nbits), .step(req_step), .last(req_last), .busy(req_busy)
  );

  always_ff @(posedge clk) begin
    if (rst || hsync_lead) ttx_req <= 1'b0;
    else                   ttx_req <= req_step;
  end

  // Request history: taps[j] is the request seen j+1 edges before sampling.
  generate
    if (DLY_MAX > 1) begin : g_dline
      logic [DLY_MAX-2:0] hist;
      always_ff @(posedge clk) begin
        if (rst || hsync_lead) hist <= '0;
        else                   hist <= {hist, ttx_req} >> 0;
      end
      assign taps = {hist, ttx_req};
    end else begin : g_direct
      assign taps = ttx_req;
    end
  endgenerate

  always_comb begin
    if (data_delay == '0)                      dsel = '0;
    else if (data_delay > DLY_W'(DLY_MAX))     dsel = DLY_IW'(DLY_MAX - 1);
    else                                       dsel = DLY_IW'(data_delay - 1'b1);
  end

  assign cap = taps[dsel];

  ttx_rate_gen #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_ins_rate (
    .clk(clk), .rst(rst), .clr(hsync_lead), .start(ins_go), .inc(inc),
    .limit(nbits), .step(ins_step), .last(ins_last), .busy(ins_busy)
  );

  assign ins_pop = ins_go || (ins_step && !ins_last);

  ttx_bit_fifo #(.DEPTH(FIFO_D)) u_fifo (
    .clk(clk), .rst(rst), .clr(hsync_lead), .push(cap), .din(ttx_bit_in),
    .pop(ins_pop), .dout(fifo_out)
  );

  always_ff @(posedge clk) begin
    if (rst || hsync_lead) begin
      ins_valid <= 1'b0;
      ins_bit   <= 1'b0;
    end else begin
      if (ins_go)        ins_valid <= 1'b1;
      else if (ins_last) ins_valid <= 1'b0;
      if (ins_pop)       ins_bit   <= fifo_out;
      else if (ins_last) ins_bit   <= 1'b0;
    end
  end
endmodule

// File: rtl/ttx_window_chk.sv
module ttx_window_chk
  import ttx_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     hsync_lead,
  input logic     field_start,
  input logic     ttx_req,
  input logic     ins_valid,
  input logic     ins_bit,
  input logic     line_ok,
  input ttx_std_e std_q,
  input logic     ins_pop
);
  int req_seen;

  always_ff @(posedge clk) begin
    if (rst || hsync_lead || field_start) req_seen <= 0;
    else if (ttx_req)                     req_seen <= req_seen + 1;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!ttx_req && !ins_valid));

  p_req_single_r2: assert property (@(posedge clk) disable iff (rst)
    ttx_req |=> !ttx_req);

  p_req_bound_r3: assert property (@(posedge clk) disable iff (rst)
    req_seen <= std_bits(std_q));

  p_bit_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && $past(ins_valid) && !$past(ins_pop) && !$past(hsync_lead))
      |-> $stable(ins_bit));

  p_unsel_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !line_ok |-> (!ttx_req && !ins_valid));
endmodule

bind ttx_window_ctrl ttx_window_chk u_chk (
  .clk(clk), .rst(rst), .hsync_lead(hsync_lead), .field_start(field_start),
  .ttx_req(ttx_req), .ins_valid(ins_valid), .ins_bit(ins_bit),
  .line_ok(line_ok), .std_q(std_q), .ins_pop(ins_pop)
);

// File: tb/ttx_window_ctrl_test.sv
module ttx_window_ctrl_test;
  localparam int LINE_CYC = 1728;
  localparam int VEC_N    = 10;
  localparam int RS       = 240;

  typedef struct packed {
    logic [1:0] std;
    logic       odd;
    logic       en;
    logic       act;
    logic [9:0] line;
  } vec_t;

  localparam vec_t VEC [VEC_N] = '{
    '{2'd0, 1'b1, 1'b1, 1'b1, 10'd7},    // R8 odd lower bound
    '{2'd0, 1'b1, 1'b1, 1'b1, 10'd20},   // R8 odd upper bound
    '{2'd0, 1'b1, 1'b1, 1'b0, 10'd21},   // R8 just above
    '{2'd0, 1'b1, 1'b1, 1'b0, 10'd6},    // R8 just below
    '{2'd1, 1'b0, 1'b1, 1'b1, 10'd320},  // R8 even lower bound
    '{2'd1, 1'b0, 1'b1, 1'b0, 10'd10},   // R8 odd range on even field
    '{2'd2, 1'b0, 1'b1, 1'b1, 10'd333},  // R8 even upper bound
    '{2'd2, 1'b1, 1'b1, 1'b0, 10'd320},  // R8 even range on odd field
    '{2'd0, 1'b1, 1'b0, 1'b0, 10'd10},   // R7 disabled field
    '{2'd1, 1'b1, 1'b1, 1'b1, 10'd15}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1, hsync_lead = 1'b0, field_start = 1'b0, field_odd = 1'b0;
  logic [9:0] line_num = '0;
  logic       ttx_en = 1'b0;
  logic [1:0] ttx_std = 2'd0;
  logic [9:0] odd_first = 10'd7, odd_last = 10'd20, even_first = 10'd320, even_last = 10'd333;
  logic [10:0] req_start = 11'(RS);
  logic [5:0] data_delay = 6'd10;
  logic       ttx_bit_in = 1'b0;
  logic       ttx_req, ins_bit, ins_valid;

  int n_chk = 0, n_bad = 0;

  ttx_window_ctrl uut (
    .clk(clk), .rst(rst), .hsync_lead(hsync_lead), .field_start(field_start),
    .field_odd(field_odd), .line_num(line_num), .ttx_en(ttx_en), .ttx_std(ttx_std),
    .odd_first(odd_first), .odd_last(odd_last), .even_first(even_first),
    .even_last(even_last), .req_start(req_start), .data_delay(data_delay),
    .ttx_bit_in(ttx_bit_in), .ttx_req(ttx_req), .ins_bit(ins_bit), .ins_valid(ins_valid)
  );

  function automatic longint e_inc(int s);  return (s == 0) ? 64'd4310812 : 64'd3558758; endfunction
  function automatic int e_bits(int s);     return (s == 0) ? 360 : (s == 1) ? 296 : 288; endfunction
  function automatic int e_ofs(int s);      return (s == 0) ? 275 : 284; endfunction
  function automatic logic pat(longint i);  return logic'(((i * 7) % 5) > 2) ^ logic'(i[3]); endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic new_field(int s, bit en);
    @(negedge clk);
    field_start = 1'b1; ttx_std = 2'(s); ttx_en = en;
    @(negedge clk);
    field_start = 1'b0;
  endtask

  task automatic run_line(logic [9:0] ln, bit odd, int s, bit act, int dly, string tag);
    logic   sched [128];
    int     nreq = 0, first_req = -1, last_req = -1, badgap = 0;
    int     nval = 0, first_val = -1, badbit = 0;
    longint inc = e_inc(s);
    longint glo = (64'd1 << 24) / inc;
    longint kexp = (longint'(e_bits(s)) * (64'd1 << 24) + inc - 1) / inc;
    for (int i = 0; i < 128; i++) sched[i] = 1'b0;
    data_delay = 6'(dly);
    @(negedge clk);
    hsync_lead = 1'b1; line_num = ln; field_odd = odd;
    @(negedge clk);
    hsync_lead = 1'b0;
    for (int t = 0; t < LINE_CYC; t++) begin
      if (ttx_req === 1'b1) begin
        if (first_req < 0) first_req = t;
        else if ((t - last_req) < glo || (t - last_req) > glo + 1) badgap++;
        last_req = t;
        sched[(t + dly) % 128] = pat(nreq);
        nreq++;
      end
      if (ins_valid === 1'b1) begin
        if (first_val < 0) first_val = t;
        if (ins_bit !== pat((longint'(t - first_val) * inc) >> 24)) badbit++;
        nval++;
      end
      ttx_bit_in = sched[(t + 1) % 128];
      sched[(t + 1) % 128] = 1'b0;
      @(negedge clk);
    end
    if (act) begin
      check(nreq == e_bits(s), {tag, "/R3 request count"}, nreq, e_bits(s));
      check(first_req >= RS + 2 && first_req <= RS + 6, {tag, "/R2 first request"}, first_req, RS + 5);
      check(badgap == 0, {tag, "/R2 request spacing"}, badgap, 0);
      check(first_val == e_ofs(s), {tag, "/R5 window start"}, first_val, e_ofs(s));
      check(nval == kexp, {tag, "/R6 window length"}, nval, kexp);
      check(badbit == 0, {tag, "/R4 R6 inserted bits"}, badbit, 0);
    end else begin
      check(nreq == 0, {tag, " requests on idle line"}, nreq, 0);
      check(nval == 0, {tag, " window on idle line"}, nval, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ttx_req == 1'b0,   "R1 ttx_req in reset",   ttx_req, 0);
    check(ins_valid == 1'b0, "R1 ins_valid in reset", ins_valid, 0);
    check(ins_bit == 1'b0,   "R1 ins_bit in reset",   ins_bit, 0);
    rst = 1'b0;

    for (int v = 0; v < VEC_N; v++) begin
      new_field(int'(VEC[v].std), VEC[v].en);
      run_line(VEC[v].line, VEC[v].odd, int'(VEC[v].std), VEC[v].act, 10,
               VEC[v].en ? "R8" : "R7");
    end

    // R4: shortest and long capture delay
    new_field(0, 1'b1);
    run_line(10'd8, 1'b1, 0, 1'b1, 1,  "R4 delay 1");
    run_line(10'd9, 1'b1, 0, 1'b1, 20, "R4 delay 20");

    // R9: standard changed mid-field is ignored
    new_field(2, 1'b1);
    @(negedge clk) ttx_std = 2'd0;
    run_line(10'd9, 1'b1, 2, 1'b1, 10, "R9");

    // R7: enable raised mid-field is ignored
    new_field(0, 1'b0);
    @(negedge clk) ttx_en = 1'b1;
    run_line(10'd9, 1'b1, 0, 1'b0, 10, "R7");

    // R1: reset clears the latched enable
    new_field(0, 1'b1);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    run_line(10'd9, 1'b1, 0, 1'b0, 10, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(150000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule